// File: doc/BRIEF.md
# SPI Successive-Approximation ADC Sample Reader

This block is an SPI master that runs a single conversion on an external successive-approximation converter and returns one right-aligned sample. The user gives a one-cycle start strobe together with a channel index, a differential-mode flag and a converter-variant selection. The variant selection gives the channel count (1, 2, 4 or 8) and the resolution (10, 12 or 13 bits). The block checks the request and builds the command byte that the variant expects. It frames the transfer with an active-low chip select and clocks the command out in SPI mode 0. It then gathers the response bits and reorders them into the sample that the variant defines.

Variants with one channel have no serial data input. For these the transfer only receives: no command is sent and the data output stays low. Variants with several channels send one command byte first. Any bits that arrive during the command byte are discarded. The sample is presented with a one-cycle valid pulse. An invalid request raises a one-cycle error pulse and runs no bus activity.

Top module: `sar_adc_reader`

## Requirements
- R1: After reset, csN is high, sclk is low, mosi is low, and busy, sampleValid and errPulse are all low.
- R2: sclk idles low and toggles every HALF_DIV system clocks while csN is low. The first rising edge comes HALF_DIV clocks after csN falls. mosi changes only together with a falling edge. miso is sampled at each rising edge.
- R3: From acceptance until the transfer ends, csN stays low without a break and then rises exactly once. A transfer has 24 sclk rising edges for multi-channel variants (8 command plus 16 receive) and 16 for single-channel variants. The receive length is ceil(resolution/8) bytes.
- R4: chanCode encodes the channel count: 0 for 1, 1 for 2, 2 for 4, 3 for 8. For 2-channel variants (chanCode=1), the command byte is sent MSB first as 0b000 1 S C 00. Here S is the inverse of diffMode (1 means single-ended) and C is channel bit 0.
- R5: For 4- and 8-channel variants (chanCode=2 or 3), the command byte is 0b01 S CCC 00, sent MSB first. S is the inverse of diffMode and CCC is the channel index. In differential mode the index selects the even/odd pair, and the index's own input is the positive one.
- R6: For single-channel variants (chanCode=0), no command is sent: mosi stays low for the whole transfer and only the 16 receive bits are clocked.
- R7: The receive buffer is cleared at the start of every transfer, and miso bits sampled during the command byte never reach the sample. byte0 is the first 8 receive bits and byte1 the next 8, each MSB first.
- R8: resCode encodes the resolution: 0 for 10 bits, 1 for 12 bits, 2 for 13 bits, 3 reserved. For multi-channel variants, the 10-bit sample is (byte0<<2)|(byte1>>6) and the 12-bit sample is (byte0<<4)|(byte1>>4), both zero-extended.
- R9: For single-channel variants, the 10-bit sample is ((byte0<<5)|(byte1>>3)) keeping its low 10 bits. The 12-bit sample is ((byte0<<7)|(byte1>>1)) keeping its low 12 bits. Both are zero-extended.
- R10: For the 13-bit variant, the sample is the low 5 bits of byte0 followed by byte1. It is sign-extended from bit 12 into a 16-bit two's-complement value.
- R11: A start strobe that arrives while busy is high is ignored. The transfer in progress keeps its channel, mode and variant, and no second transfer or error follows.
- R12: Three kinds of request are unsupported: resCode=3, a 13-bit resolution with more than one channel, and a channel index not below the channel count. Such a request raises errPulse for exactly one cycle, one cycle after the start strobe. It raises no sampleValid and does not lower csN.
- R13: sampleValid pulses for one cycle, one cycle after csN rises. sample holds its value until the next valid transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| channel | input | 3 | Channel index (pair selector in differential mode) |
| diffMode | input | 1 | 1 = differential, 0 = single-ended |
| chanCode | input | 2 | Channel count code: 0=1, 1=2, 2=4, 3=8 |
| resCode | input | 2 | Resolution code: 0=10, 1=12, 2=13, 3=reserved |
| busy | output | 1 | A request is being served |
| sample | output | SAMPLE_W | Right-aligned sample, sign-extended for 13 bits |
| sampleValid | output | 1 | One-cycle pulse when sample updates |
| errPulse | output | 1 | One-cycle pulse for a rejected request |
| sclk | output | 1 | SPI clock, mode 0 |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial command to the converter |
| miso | input | 1 | Serial data from the converter |

## Verification
The bench sweeps every combination of channel code, resolution code, channel index and mode. A converter model in the bench feeds patterns that put a deliberate junk byte in the command slot. A reader that kept command-phase bits, or that cleared nothing between transfers, would return shifted samples. A wrong shift on one variant, or a missing sign extension for 13 bits, shows up as a mismatch in the arithmetic expected value, and near-boundary patterns such as 0x1000 and 0x0FFF drive the sign bit both ways. The bench also covers these failures: a command byte with the wrong flag position or polarity, a single-channel transfer that still sends a command, an extra or missing clock edge, a chip select that drops mid-frame, and an invalid request that still clocks the bus. A strobe injected mid-transfer catches a design that re-latches its inputs while busy.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  localparam int CMD_BITS     = 8;
  localparam int MAX_RES      = 13;
  localparam int RX_BYTES_MAX = (MAX_RES + 7) / 8;
  localparam int RX_BITS      = RX_BYTES_MAX * 8;
  localparam int FRAME_BITS   = CMD_BITS + RX_BITS;
  localparam int BIT_CNT_W    = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    CH_ONE   = 2'd0,
    CH_TWO   = 2'd1,
    CH_FOUR  = 2'd2,
    CH_EIGHT = 2'd3
  } chanCode_e;

  typedef enum logic [1:0] {
    RES_10   = 2'd0,
    RES_12   = 2'd1,
    RES_13   = 2'd2,
    RES_RSVD = 2'd3
  } resCode_e;

  // strobes from the sequencer to the shift/extract datapath
  typedef struct packed {
    logic loadCfg;   // latch request, load command, clear receive buffer
    logic shiftOut;  // advance the command register (falling sclk)
    logic sampleIn;  // capture miso (rising sclk, receive phase)
    logic finish;    // frame complete, publish the sample
  } ctrlStrobes_t;

  function automatic int resolutionBits(resCode_e r);
    case (r)
      RES_10:  return 10;
      RES_12:  return 12;
      RES_13:  return 13;
      default: return 0;
    endcase
  endfunction

  function automatic logic variantOk(chanCode_e c, resCode_e r, logic [2:0] ch);
    logic ok;
    ok = 1'b1;
    if (r == RES_RSVD) ok = 1'b0;
    if ((c != CH_ONE) && (r == RES_13)) ok = 1'b0;
    if ({1'b0, ch} >= (4'd1 << c)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [BIT_CNT_W-1:0] cmdLength(chanCode_e c);
    return (c == CH_ONE) ? '0 : BIT_CNT_W'(CMD_BITS);
  endfunction

  function automatic logic [BIT_CNT_W-1:0] frameLength(chanCode_e c, resCode_e r);
    int n;
    n = ((resolutionBits(r) + 7) / 8) * 8;
    if (c != CH_ONE) n = n + CMD_BITS;
    return BIT_CNT_W'(n);
  endfunction

endpackage

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  chanCode_e    chanCode,
  input  resCode_e     resCode,
  input  logic [2:0]   channel,
  output ctrlStrobes_t strobes,
  output logic         sclk,
  output logic         csN,
  output logic         busy,
  output logic         errPulse
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} state_e;

  state_e               state;
  logic [DIV_W-1:0]     divCnt;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BIT_CNT_W-1:0] lastBit;
  logic [BIT_CNT_W-1:0] cmdLen;
  logic                 reqOk;
  logic                 accept;
  logic                 reject;
  logic                 halfTick;
  logic                 riseNow;
  logic                 fallNow;
  logic                 lastFall;

  always_comb begin
    reqOk    = variantOk(chanCode, resCode, channel);
    accept   = (state == ST_IDLE) && start && reqOk;
    reject   = (state == ST_IDLE) && start && !reqOk;
    halfTick = (state == ST_SHIFT) && (divCnt == DIV_LAST);
    riseNow  = halfTick && !sclk;
    fallNow  = halfTick && sclk;
    lastFall = fallNow && (bitCnt == lastBit);

    strobes.loadCfg  = accept;
    strobes.shiftOut = fallNow;
    strobes.sampleIn = riseNow && (bitCnt >= cmdLen);
    strobes.finish   = (state == ST_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      bitCnt   <= '0;
      lastBit  <= '0;
      cmdLen   <= '0;
      sclk     <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= reject;
      case (state)
        ST_IDLE: begin
          sclk <= 1'b0;
          if (accept) begin
            state   <= ST_SHIFT;
            divCnt  <= '0;
            bitCnt  <= '0;
            cmdLen  <= cmdLength(chanCode);
            lastBit <= frameLength(chanCode, resCode) - 1'b1;
          end
        end
        ST_SHIFT: begin
          divCnt <= halfTick ? '0 : divCnt + 1'b1;
          if (halfTick) sclk <= !sclk;
          if (fallNow) bitCnt <= bitCnt + 1'b1;
          if (lastFall) state <= ST_DONE;
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign csN  = (state != ST_SHIFT);

endmodule

// File: rtl/sar_adc_datapath.sv
module sar_adc_datapath
  import sar_adc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  chanCode_e           chanCode,
  input  resCode_e            resCode,
  input  logic [2:0]          channel,
  input  logic                diffMode,
  input  logic                miso,
  output logic                mosi,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sampleValid
);

  localparam int EXT_W = SAMPLE_W - MAX_RES;

  chanCode_e             cfgChan;
  resCode_e              cfgRes;
  logic [CMD_BITS-1:0]   cmdByte;
  logic [CMD_BITS-1:0]   txReg;
  logic [RX_BITS-1:0]    rxReg;
  logic [7:0]            byte0;
  logic [7:0]            byte1;
  logic [MAX_RES-1:0]    raw13;
  logic [SAMPLE_W-1:0]   signedWide;
  logic [SAMPLE_W-1:0]   extracted;

  // command byte layout depends on the channel count
  always_comb begin
    case (chanCode)
      CH_ONE:  cmdByte = '0;
      CH_TWO:  cmdByte = {3'b000, 1'b1, ~diffMode, channel[0], 2'b00};
      default: cmdByte = {1'b0, 1'b1, ~diffMode, channel, 2'b00};
    endcase
  end

  assign byte0 = rxReg[RX_BITS-1 -: 8];
  assign byte1 = rxReg[7:0];
  assign raw13 = {byte0[4:0], byte1};

  generate
    if (EXT_W > 0) begin : g_ext
      assign signedWide = {{EXT_W{raw13[MAX_RES-1]}}, raw13};
    end else begin : g_noext
      assign signedWide = raw13[SAMPLE_W-1:0];
    end
  endgenerate

  always_comb begin
    extracted = '0;
    if (cfgChan == CH_ONE) begin
      case (cfgRes)
        RES_10:  extracted = SAMPLE_W'({byte0[4:0], byte1[7:3]});
        RES_12:  extracted = SAMPLE_W'({byte0[4:0], byte1[7:1]});
        default: extracted = signedWide;
      endcase
    end else begin
      case (cfgRes)
        RES_10:  extracted = SAMPLE_W'({byte0, byte1[7:6]});
        default: extracted = SAMPLE_W'({byte0, byte1[7:4]});
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgChan     <= CH_ONE;
      cfgRes      <= RES_10;
      txReg       <= '0;
      rxReg       <= '0;
      sample      <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.finish;
      if (strobes.loadCfg) begin
        cfgChan <= chanCode;
        cfgRes  <= resCode;
        txReg   <= cmdByte;
        rxReg   <= '0;
      end else begin
        if (strobes.shiftOut) txReg <= {txReg[CMD_BITS-2:0], 1'b0};
        if (strobes.sampleIn) rxReg <= {rxReg[RX_BITS-2:0], miso};
      end
      if (strobes.finish) sample <= extracted;
    end
  end

  assign mosi = txReg[CMD_BITS-1];

endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
  import sar_adc_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          channel,
  input  logic                diffMode,
  input  logic [1:0]          chanCode,
  input  logic [1:0]          resCode,
  output logic                busy,
  output logic [SAMPLE_W-1:0] sample,
  output logic                sampleValid,
  output logic                errPulse,
  output logic                sclk,
  output logic                csN,
  output logic                mosi,
  input  logic                miso
);

  ctrlStrobes_t strobes;
  chanCode_e    chanSel;
  resCode_e     resSel;

  assign chanSel = chanCode_e'(chanCode);
  assign resSel  = resCode_e'(resCode);

  sar_adc_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .chanCode (chanSel),
    .resCode  (resSel),
    .channel  (channel),
    .strobes  (strobes),
    .sclk     (sclk),
    .csN      (csN),
    .busy     (busy),
    .errPulse (errPulse)
  );

  sar_adc_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .chanCode    (chanSel),
    .resCode     (resSel),
    .channel     (channel),
    .diffMode    (diffMode),
    .miso        (miso),
    .mosi        (mosi),
    .sample      (sample),
    .sampleValid (sampleValid)
  );

endmodule

// File: rtl/sar_adc_reader_checker.sv
module sar_adc_reader_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic csN,
  input logic sclk,
  input logic mosi,
  input logic sampleValid,
  input logic errPulse
);

  // R3: chip select only low while a request is being served
  assert_cs_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  // R2: mode 0 clock rests low outside a frame
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R2: data out holds while the clock is high
  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R13: valid is a single-cycle pulse after the frame closes
  assert_valid_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  assert_valid_after_frame_R13: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (csN && $past(csN)));

  // R12: error only answers an idle-time request, with no bus activity
  assert_err_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> ($past(start) && !$past(busy)));

  assert_err_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (!sampleValid && csN));

  // R11: a strobe during a transfer never yields an error
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !errPulse);

endmodule

bind sar_adc_reader sar_adc_reader_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .busy        (busy),
  .csN         (csN),
  .sclk        (sclk),
  .mosi        (mosi),
  .sampleValid (sampleValid),
  .errPulse    (errPulse)
);

// File: tb/sar_adc_reader_bench.sv
`timescale 1ns/1ps
module sar_adc_reader_bench;

  localparam int HALF = 2;
  localparam real TCLK = 5.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  channel = '0;
  logic        diffMode = 1'b0;
  logic [1:0]  chanCode = '0;
  logic [1:0]  resCode = '0;
  logic        busy;
  logic [15:0] sample;
  logic        sampleValid;
  logic        errPulse;
  logic        sclk;
  logic        csN;
  logic        mosi;
  logic        miso;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(TCLK / 2.0) clk = ~clk;

  sar_adc_reader #(.HALF_DIV(HALF), .SAMPLE_W(16)) u_sar_adc_reader (
    .clk(clk), .rstN(rstN), .start(start), .channel(channel), .diffMode(diffMode),
    .chanCode(chanCode), .resCode(resCode), .busy(busy), .sample(sample),
    .sampleValid(sampleValid), .errPulse(errPulse), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  // converter model: counters only grow, the tasks take snapshots
  logic [23:0] loadFrame = '0;
  int          baseFall = 0;
  int          fallCnt = 0;
  int          riseCnt = 0;
  int          csRiseCnt = 0;
  logic [31:0] mosiHist = '0;
  realtime     csFallT = 0;
  realtime     lastRiseT = 0;
  int          fIdx;

  always @(negedge sclk) fallCnt++;
  always @(posedge sclk) begin
    riseCnt++;
    lastRiseT = $realtime;
    mosiHist = {mosiHist[30:0], mosi};
  end
  always @(posedge csN) csRiseCnt++;
  always @(negedge csN) csFallT = $realtime;

  always_comb begin
    fIdx = fallCnt - baseFall;
    miso = (fIdx >= 0 && fIdx < 24) ? loadFrame[23 - fIdx] : 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit supported(input int cc, input int rc, input int ch);
    if (rc == 3) return 1'b0;
    if (cc != 0 && rc == 2) return 1'b0;
    if (ch >= (1 << cc)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [15:0] expSample(input int cc, input int rc, input int pat);
    int b0, b1, v;
    b0 = (pat >> 8) & 255;
    b1 = pat & 255;
    if (cc != 0) v = (rc == 0) ? ((b0 << 2) | (b1 >> 6)) : ((b0 << 4) | (b1 >> 4));
    else if (rc == 0) v = ((b0 << 5) | (b1 >> 3)) & 1023;
    else if (rc == 1) v = ((b0 << 7) | (b1 >> 1)) & 4095;
    else begin
      v = ((b0 & 31) << 8) | b1;
      if (v >= 4096) v = v - 8192;
    end
    return v[15:0];
  endfunction

  function automatic logic [7:0] expCmd(input int cc, input int ch, input int d);
    int v;
    if (cc == 1) v = 16 | ((d != 0 ? 0 : 1) << 3) | ((ch & 1) << 2);
    else         v = 64 | ((d != 0 ? 0 : 1) << 5) | (ch << 2);
    return v[7:0];
  endfunction

  task automatic runTxn(input int cc, input int rc, input int ch, input int d,
                        input logic [15:0] pat, input logic [7:0] junk, input bit inject);
    int r0, c0, rises, csr, nBits, span, expSpan;
    bit gotV, gotE, ok;
    logic [15:0] smp;
    string sreq;
    ok = supported(cc, rc, ch);
    loadFrame = (cc == 0) ? {pat, 8'h00} : {junk, pat};
    baseFall = fallCnt;
    r0 = riseCnt;
    c0 = csRiseCnt;
    @(negedge clk);
    chanCode = 2'(cc); resCode = 2'(rc); channel = 3'(ch); diffMode = d[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gotV = 0; gotE = 0; smp = '0;
    for (int i = 0; i < 400; i++) begin
      if (inject && i == 8) begin
        channel = ~3'(ch); diffMode = ~d[0]; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (sampleValid) begin gotV = 1; smp = sample; break; end
      if (errPulse) gotE = 1;
      if (gotE && i > 40) break;
      @(negedge clk);
    end
    start = 1'b0;
    rises = riseCnt - r0;
    csr = csRiseCnt - c0;
    nBits = (cc == 0) ? 16 : 24;
    if (ok) begin
      check(gotV && !gotE, "R13", "valid without error", {gotV, gotE}, 2'b10);
      sreq = (cc == 0) ? ((rc == 2) ? "R10" : "R9") : "R8 R7";
      check(smp == expSample(cc, rc, pat), sreq, "sample", smp, expSample(cc, rc, pat));
      check(rises == nBits, "R3", "sclk edges per frame", rises, nBits);
      check(csr == 1, inject ? "R11" : "R3", "csN rises per request", csr, 1);
      if (cc == 0)
        check(mosiHist[15:0] == 16'h0, "R6", "mosi quiet", mosiHist[15:0], 0);
      else
        check(mosiHist[23:16] == expCmd(cc, ch, d), (cc == 1) ? "R4" : "R5",
              "command byte", mosiHist[23:16], expCmd(cc, ch, d));
      span = int'((lastRiseT - csFallT) * 1000.0);
      expSpan = int'((HALF + (nBits - 1) * 2 * HALF) * TCLK * 1000.0);
      check(span == expSpan, "R2", "csN fall to last rise (ps)", span, expSpan);
      repeat (3) @(negedge clk);
      check(sample == smp && !sampleValid, "R13", "sample held", sample, smp);
    end else begin
      check(gotE && !gotV, "R12", "error without valid", {gotE, gotV}, 2'b10);
      check(rises == 0 && csr == 0, "R12", "no bus activity", rises + csr, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int idx;
    logic [15:0] pat;
    repeat (4) @(negedge clk);
    check(csN && !sclk && !mosi && !busy && !sampleValid && !errPulse, "R1",
          "reset state", {csN, sclk, mosi, busy, sampleValid, errPulse}, 6'b100000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN && !sclk && !busy, "R1", "idle after reset", {csN, sclk, busy}, 3'b100);

    idx = 0;
    for (int cc = 0; cc < 4; cc++)
      for (int rc = 0; rc < 4; rc++)
        for (int ch = 0; ch < 8; ch++)
          for (int d = 0; d < 2; d++) begin
            pat = 16'(idx * 16'h3B5D + 16'h1234);
            runTxn(cc, rc, ch, d, pat, (idx[0] ? 8'hFF : 8'hA7), 1'b0);
            idx++;
          end

    // boundary patterns on every supported resolution
    for (int cc = 0; cc < 4; cc += 3)
      for (int rc = 0; rc < 3; rc++)
        for (int p = 0; p < 6; p++) begin
          case (p)
            0: pat = 16'h0000;
            1: pat = 16'hFFFF;
            2: pat = 16'h1000;
            3: pat = 16'h0FFF;
            4: pat = 16'hA55A;
            default: pat = 16'h5AA5;
          endcase
          runTxn(cc, rc, 0, p & 1, pat, 8'hFF, 1'b0);
        end

    // R11: strobes injected mid-transfer
    runTxn(3, 1, 5, 0, 16'hC3A9, 8'hFF, 1'b1);
    runTxn(1, 0, 1, 1, 16'h7E81, 8'h00, 1'b1);
    runTxn(0, 2, 0, 0, 16'h19F0, 8'h00, 1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule